// File: doc/BRIEF.md
# In-Order Reorder Buffer with Fence Gating

This block is the retirement queue of an out-of-order core. An issue stage presents up to four micro-ops per cycle, each tagged with a kind. The block writes the accepted ops into a circular array at the tail and reports how many it took and the index of the first one. Execution units later report completion by sending back an entry index. Each cycle the block retires the longest finished run at the head, up to four entries, strictly in program order.

Some ops never visit an execution unit: no-ops, register-zeroing idioms and fences. These ops are written with their finished flag already set, so they retire as soon as they reach the head. A fence also acts as a barrier. Nothing behind it is allocated until every older entry has committed, and no later op is allocated until the fence itself has committed. The head and tail pointers each carry one bit more than the index, which lets the block tell a full buffer from an empty one.

Top module: `inorder_rob`

## Requirements
- R1: After synchronous reset the buffer is empty: the commit count is 0 and the commit index is 0. With a request count of 0, the accepted count is 0 and stall is low.
- R2: Accepted ops are written at consecutive indices, in slot order, starting at the reported tail index. Up to four ops are accepted per cycle.
- R3: Kind codes are 0 = needs an execution unit, 1 = no-op or zeroing idiom, 2 = fence, 3 = treated as 0. Ops of kind 1 and kind 2 are written already finished. They appear in the commit count in the cycle after they are accepted.
- R4: An op of kind 0 stays unfinished until a completion pulse carries its index. It can appear in the commit count in the cycle after that pulse, and not earlier.
- R5: Commit starts at the head and stops at the first unfinished entry, even when younger entries are already finished. The commit index advances by the commit count each cycle.
- R6: At most four entries commit per cycle.
- R7: When a fence sits in a slot other than slot 0, only the slots ahead of it are accepted in that cycle.
- R8: A fence in slot 0 is accepted only when the buffer is empty at the start of the cycle. It is accepted alone, even if more slots are requested.
- R9: While an accepted fence has not yet committed, no op is accepted.
- R10: Stall is high exactly when fewer ops are accepted than requested. When free entries are fewer than requested, exactly the free count is accepted.
- R11: Indices wrap modulo the depth (32 by default). A buffer holding 32 entries accepts nothing, and the next allocation after a commit lands at index 0.
- R12: A request count above four is treated as four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_cnt | input | 3 | Number of ops requested this cycle |
| iss_kind | input | 8 | Kind of slot s in bits 2s+1:2s |
| iss_accept | output | 3 | Number of ops accepted this cycle |
| iss_tail | output | 5 | Index given to the first accepted op |
| iss_stall | output | 1 | Fewer ops accepted than requested |
| cmp_valid | input | 1 | Completion pulse |
| cmp_idx | input | 5 | Entry index being completed |
| cmt_cnt | output | 3 | Entries committing this cycle |
| cmt_idx | output | 5 | Index of the oldest entry (head) |

## Verification
The issue outputs (accept count, tail index and stall) are combinational from the request and the registered state. The bench therefore checks them one time step after driving the inputs, inside the same cycle. The commit outputs depend only on registered state. An op of kind 1 or 2 shows up in the commit count one cycle after its accepting edge, and an op of kind 0 shows up one cycle after the edge that captured its completion pulse. Inputs are driven at the falling edge and checked before the next rising edge, so every expected value is sampled in exactly the cycle it is due. The fence scenarios also confirm that the head entries are counted as occupied for the whole cycle in which they commit.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OP_EXEC   = 2'd0,
        OP_NOEXEC = 2'd1,
        OP_FENCE  = 2'd2,
        OP_RSVD   = 2'd3
    } op_kind_e;

    function automatic logic kind_needs_unit(op_kind_e k);
        return (k != OP_NOEXEC) && (k != OP_FENCE);
    endfunction

    function automatic logic kind_is_fence(op_kind_e k);
        return k == OP_FENCE;
    endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc
    import rob_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 4,
    parameter int CNT_W = $clog2(WIDTH + 1),
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] req_cnt,
    input  op_kind_e         kinds [WIDTH],
    input  logic [PTR_W-1:0] occ,
    input  logic             fence_pending,
    output logic [CNT_W-1:0] accept,
    output logic             fence_alloc,
    output logic             stall
);

    logic [CNT_W-1:0] req_eff;
    logic [CNT_W-1:0] lim;
    logic             fence_head;
    logic             found;
    logic [PTR_W-1:0] free_cnt;

    always_comb begin
        req_eff    = (32'(req_cnt) > WIDTH) ? CNT_W'(WIDTH) : req_cnt;
        lim        = req_eff;
        fence_head = 1'b0;
        found      = 1'b0;
        for (int s = 0; s < WIDTH; s++) begin
            if (!found && (s < int'(req_eff)) && kind_is_fence(kinds[s])) begin
                found = 1'b1;
                lim   = CNT_W'(s);
                if (s == 0) fence_head = 1'b1;
            end
        end
        free_cnt    = PTR_W'(DEPTH) - occ;
        accept      = '0;
        fence_alloc = 1'b0;
        if (!fence_pending) begin
            if (fence_head) begin
                if (occ == '0) begin
                    accept      = CNT_W'(1);
                    fence_alloc = 1'b1;
                end
            end else if (32'(lim) > 32'(free_cnt)) begin
                accept = CNT_W'(free_cnt);
            end else begin
                accept = lim;
            end
        end
        stall = (accept != req_eff);
    end

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 4,
    parameter int CNT_W = $clog2(WIDTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] tail_idx,
    input  logic [CNT_W-1:0] accept,
    input  op_kind_e         kinds [WIDTH],
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_idx,
    output logic [DEPTH-1:0] done,
    output logic [DEPTH-1:0] is_fence
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [IDX_W-1:0] off;
        logic             wr;
        op_kind_e         wkind;

        assign off = IDX_W'(i) - tail_idx;
        assign wr  = 32'(off) < 32'(accept);

        always_comb begin
            wkind = OP_EXEC;
            for (int s = 0; s < WIDTH; s++) begin
                if (off == IDX_W'(s)) wkind = kinds[s];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                done[i]     <= 1'b0;
                is_fence[i] <= 1'b0;
            end else if (wr) begin
                done[i]     <= !kind_needs_unit(wkind);
                is_fence[i] <= kind_is_fence(wkind);
            end else if (cmp_valid && (cmp_idx == IDX_W'(i))) begin
                done[i]     <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rob_commit.sv
module rob_commit #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 4,
    parameter int CNT_W = $clog2(WIDTH + 1),
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PTR_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0] done,
    input  logic [DEPTH-1:0] is_fence,
    input  logic [IDX_W-1:0] head_idx,
    input  logic [PTR_W-1:0] occ,
    output logic [CNT_W-1:0] cnt,
    output logic             fence_retired
);

    logic             run;
    logic [IDX_W-1:0] idx;

    always_comb begin
        run           = 1'b1;
        cnt           = '0;
        fence_retired = 1'b0;
        idx           = head_idx;
        for (int s = 0; s < WIDTH; s++) begin
            idx = head_idx + IDX_W'(s);
            if (run && (s < int'(occ)) && done[idx]) begin
                cnt = cnt + CNT_W'(1);
                if (is_fence[idx]) fence_retired = 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/inorder_rob.sv
module inorder_rob
    import rob_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   iss_cnt,
    input  logic [2*WIDTH-1:0] iss_kind,
    output logic [CNT_W-1:0]   iss_accept,
    output logic [IDX_W-1:0]   iss_tail,
    output logic               iss_stall,
    input  logic               cmp_valid,
    input  logic [IDX_W-1:0]   cmp_idx,
    output logic [CNT_W-1:0]   cmt_cnt,
    output logic [IDX_W-1:0]   cmt_idx
);

    logic [PTR_W-1:0] head_ptr, tail_ptr, occ;
    logic             fence_pending;
    logic             fence_alloc;
    logic             fence_retired;
    logic [DEPTH-1:0] done_v, fence_v;
    op_kind_e         kinds [WIDTH];

    for (genvar s = 0; s < WIDTH; s++) begin : g_kind
        assign kinds[s] = op_kind_e'(iss_kind[2*s +: 2]);
    end

    assign occ = tail_ptr - head_ptr;

    rob_alloc #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_alloc (
        .req_cnt       (iss_cnt),
        .kinds         (kinds),
        .occ           (occ),
        .fence_pending (fence_pending),
        .accept        (iss_accept),
        .fence_alloc   (fence_alloc),
        .stall         (iss_stall)
    );

    rob_entries #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ent (
        .clk       (clk),
        .rst       (rst),
        .tail_idx  (tail_ptr[IDX_W-1:0]),
        .accept    (iss_accept),
        .kinds     (kinds),
        .cmp_valid (cmp_valid),
        .cmp_idx   (cmp_idx),
        .done      (done_v),
        .is_fence  (fence_v)
    );

    rob_commit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_cmt (
        .done          (done_v),
        .is_fence      (fence_v),
        .head_idx      (head_ptr[IDX_W-1:0]),
        .occ           (occ),
        .cnt           (cmt_cnt),
        .fence_retired (fence_retired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr      <= '0;
            tail_ptr      <= '0;
            fence_pending <= 1'b0;
        end else begin
            head_ptr      <= head_ptr + PTR_W'(cmt_cnt);
            tail_ptr      <= tail_ptr + PTR_W'(iss_accept);
            fence_pending <= (fence_pending && !fence_retired) || fence_alloc;
        end
    end

    assign iss_tail = tail_ptr[IDX_W-1:0];
    assign cmt_idx  = head_ptr[IDX_W-1:0];

endmodule

// File: rtl/inorder_rob_chk.sv
module inorder_rob_chk #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 4,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PTR_W = IDX_W + 1,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] iss_cnt,
    input logic [CNT_W-1:0] iss_accept,
    input logic             iss_stall,
    input logic [CNT_W-1:0] cmt_cnt,
    input logic [IDX_W-1:0] cmt_idx,
    input logic [PTR_W-1:0] occ,
    input logic             fence_pending
);

    p_accept_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (32'(iss_accept) <= WIDTH) && (iss_accept <= iss_cnt));

    p_short_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (32'(iss_cnt) > DEPTH - 32'(occ)) |-> iss_stall);

    p_fence_hold_r9: assert property (@(posedge clk) disable iff (rst)
        fence_pending |-> (iss_accept == '0));

    p_commit_width_r6: assert property (@(posedge clk) disable iff (rst)
        (32'(cmt_cnt) <= WIDTH) && (32'(cmt_cnt) <= 32'(occ)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        32'(occ) <= DEPTH);

    p_head_step_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cmt_idx == $past(cmt_idx) + IDX_W'($past(cmt_cnt))));

endmodule

bind inorder_rob inorder_rob_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .iss_cnt       (iss_cnt),
    .iss_accept    (iss_accept),
    .iss_stall     (iss_stall),
    .cmt_cnt       (cmt_cnt),
    .cmt_idx       (cmt_idx),
    .occ           (occ),
    .fence_pending (fence_pending)
);

// File: tb/inorder_rob_tb.sv
module inorder_rob_tb;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] iss_cnt = '0;
    logic [7:0] iss_kind = '0;
    logic [2:0] iss_accept;
    logic [4:0] iss_tail;
    logic       iss_stall;
    logic       cmp_valid = 1'b0;
    logic [4:0] cmp_idx = '0;
    logic [2:0] cmt_cnt;
    logic [4:0] cmt_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_f = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inorder_rob u_dut (
        .clk(clk), .rst(rst),
        .iss_cnt(iss_cnt), .iss_kind(iss_kind),
        .iss_accept(iss_accept), .iss_tail(iss_tail), .iss_stall(iss_stall),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
        .cmt_cnt(cmt_cnt), .cmt_idx(cmt_idx)
    );

    function automatic logic [7:0] pk(op_kind_e k0, op_kind_e k1, op_kind_e k2, op_kind_e k3);
        return {k3, k2, k1, k0};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(int n, logic [7:0] k, bit cv, int ci);
        iss_cnt   = 3'(n);
        iss_kind  = k;
        cmp_valid = cv;
        cmp_idx   = 5'(ci);
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(0, '0, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        drive(0, '0, 0, 0);
        chk("R1", "cmt_cnt", cmt_cnt, 0);
        chk("R1", "cmt_idx", cmt_idx, 0);
        chk("R1", "accept", iss_accept, 0);
        chk("R1", "stall", iss_stall, 0);
    endtask

    task automatic t_exec_order();
        do_reset();
        drive(3, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R2", "accept", iss_accept, 3);
        chk("R2", "tail", iss_tail, 0);
        chk("R2", "stall", iss_stall, 0);
        tick();
        drive(0, '0, 1, 1);
        chk("R4", "cmt_cnt before completion", cmt_cnt, 0);
        tick();
        drive(0, '0, 1, 0);
        chk("R5", "cmt_cnt with head unfinished", cmt_cnt, 0);
        tick();
        drive(0, '0, 0, 0);
        chk("R4", "cmt_cnt after completion", cmt_cnt, 2);
        chk("R5", "cmt_idx", cmt_idx, 0);
        tick();
        drive(0, '0, 1, 2);
        chk("R5", "cmt_idx advanced", cmt_idx, 2);
        chk("R5", "cmt_cnt idle", cmt_cnt, 0);
        tick();
        drive(0, '0, 0, 0);
        chk("R4", "cmt_cnt last", cmt_cnt, 1);
        tick();
        drive(4, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R2", "tail after three", iss_tail, 3);
        chk("R2", "accept four", iss_accept, 4);
        tick();
    endtask

    task automatic t_noexec();
        do_reset();
        drive(4, pk(OP_NOEXEC, OP_NOEXEC, OP_NOEXEC, OP_NOEXEC), 0, 0);
        chk("R3", "accept", iss_accept, 4);
        tick();
        drive(0, '0, 0, 0);
        chk("R3", "cmt_cnt next cycle", cmt_cnt, 4);
        tick();
    endtask

    task automatic t_commit_width();
        do_reset();
        drive(4, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        tick();
        drive(4, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R2", "second tail", iss_tail, 4);
        tick();
        for (int j = 7; j >= 0; j--) begin
            drive(0, '0, 1, j);
            chk("R5", "no commit while head open", cmt_cnt, 0);
            tick();
        end
        drive(0, '0, 0, 0);
        chk("R6", "first burst", cmt_cnt, 4);
        chk("R6", "first idx", cmt_idx, 0);
        tick();
        chk("R6", "second burst", cmt_cnt, 4);
        chk("R6", "second idx", cmt_idx, 4);
        tick();
        chk("R6", "drained idx", cmt_idx, 8);
        chk("R6", "drained cnt", cmt_cnt, 0);
    endtask

    task automatic t_fence();
        do_reset();
        drive(4, pk(OP_EXEC, OP_NOEXEC, OP_FENCE, OP_EXEC), 0, 0);
        chk("R7", "accept before fence", iss_accept, 2);
        chk("R7", "stall", iss_stall, 1);
        tick();
        drive(2, pk(OP_FENCE, OP_EXEC, OP_EXEC, OP_EXEC), 1, 0);
        chk("R8", "fence waits, not empty", iss_accept, 0);
        chk("R8", "stall", iss_stall, 1);
        tick();
        drive(2, pk(OP_FENCE, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R8", "fence waits during commit", iss_accept, 0);
        chk("R5", "older commit", cmt_cnt, 2);
        tick();
        drive(2, pk(OP_FENCE, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R8", "fence alone", iss_accept, 1);
        chk("R8", "fence tail", iss_tail, 2);
        chk("R8", "stall with op behind", iss_stall, 1);
        tick();
        drive(1, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R9", "blocked by fence", iss_accept, 0);
        chk("R9", "stall", iss_stall, 1);
        chk("R3", "fence commits", cmt_cnt, 1);
        tick();
        drive(1, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R9", "released", iss_accept, 1);
        chk("R9", "tail", iss_tail, 3);
        chk("R9", "stall low", iss_stall, 0);
        tick();
    endtask

    task automatic t_full();
        do_reset();
        for (int j = 0; j < 8; j++) begin
            drive(4, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
            chk("R11", "fill accept", iss_accept, 4);
            chk("R11", "fill tail", iss_tail, j * 4);
            tick();
        end
        drive(1, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 1, 0);
        chk("R11", "full accepts none", iss_accept, 0);
        chk("R10", "full stall", iss_stall, 1);
        chk("R11", "full not empty", cmt_cnt, 0);
        tick();
        drive(2, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R10", "no space during commit", iss_accept, 0);
        chk("R4", "head commits", cmt_cnt, 1);
        tick();
        drive(2, pk(OP_EXEC, OP_EXEC, OP_EXEC, OP_EXEC), 0, 0);
        chk("R10", "partial accept", iss_accept, 1);
        chk("R10", "partial stall", iss_stall, 1);
        chk("R11", "wrapped tail", iss_tail, 0);
        tick();
    endtask

    task automatic t_clamp();
        do_reset();
        drive(7, pk(OP_NOEXEC, OP_NOEXEC, OP_NOEXEC, OP_NOEXEC), 0, 0);
        chk("R12", "clamped accept", iss_accept, 4);
        chk("R12", "no stall", iss_stall, 0);
        tick();
        drive(0, '0, 0, 0);
        chk("R12", "commit four", cmt_cnt, 4);
        tick();
    endtask

    task automatic summary();
        if (!done_f) begin
            done_f = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_exec_order();
        t_noexec();
        t_commit_width();
        t_fence();
        t_full();
        t_clamp();
        summary();
    end

endmodule